// File: doc/BRIEF.md
# Serial-DAC Successive-Approximation Sequencer

This block controls a successive-approximation converter whose DAC takes its code one bit at a time and builds its output by charge redistribution. It works out the result from the most significant bit down. For each decision it sends a trial code to the DAC. The trial code is a 1 in the new position, followed by every bit already settled. Each streamed bit takes two charge steps: a load step that sets the bit on the DAC data line, then a share step that averages the new charge into the DAC's running voltage. The bit sent last ends up with the largest weight. After the last share step of a decision, the block pulses a compare strobe and records the comparator answer as the new result bit.

Decision k streams k bits, so the work per conversion grows with the square of the resolution rather than linearly. The block fits slow, small-area converters where a single serial DAC replaces a binary-weighted array. The DAC model clears its running voltage on each compare strobe, so every decision starts from zero.

Top module: `sar_serial_seq`

## Requirements
- R1: While reset is held and right after it, no strobe is active, `dac_bit` is 0, `done` is 0 and `result` is all zeros.
- R2: Decision k (k = 1 for the first) streams exactly k bits. Each bit is a `chg_load` cycle followed straight after by a `chg_share` cycle. At most one of `chg_load`, `chg_share` and `cmp_strobe` is high in any cycle.
- R3: Within decision k, the first streamed bit is the trial 1. It is followed by the settled bits in order of rising significance, so the most significant result bit is streamed last. `dac_bit` holds the same value across a load cycle and the share cycle that follows it.
- R4: `cmp_strobe` is high for exactly the one cycle after the last share step of each decision. `cmp_in` is sampled in that cycle: 1 (input at or above the DAC level) keeps the new bit at 1, and 0 clears it.
- R5: The first decision sets `result[N-1]`, and each later decision sets the next lower bit. For an input equal to v/2^N, the result is v.
- R6: One conversion issues N(N+1) charge strobes in total. `done` rises N(N+1)+N clock edges after the edge that accepts `start`.
- R7: `done` rises on the same edge that loads the final `result`. It stays high until the next accepted start, and it is low from the first cycle of a new conversion.
- R8: `start` is ignored while a conversion is running. The strobe sequence and the finish time are unchanged.
- R9: With N = 4, an input of 13/16 of full scale gives `result` = 4'b1101.
- R10: `result` keeps its previous value throughout a conversion and changes only on the edge where `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request; accepted only when idle |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_bit | output | 1 | Serial DAC data bit |
| chg_load | output | 1 | Charge step 1: load the data bit |
| chg_share | output | 1 | Charge step 2: share charge with the running voltage |
| cmp_strobe | output | 1 | Comparator sample strobe |
| result | output | RES_BITS | Final conversion code |
| done | output | 1 | Conversion complete, held until the next start |

## Verification
The edge that accepts `start` is counted as edge zero. Outputs are read on falling edges. The first load is seen one cycle after acceptance, and each decision k then takes 2k+1 cycles, so the bench knows the exact cycle for every strobe and every `dac_bit` value. It compares each of these against a sequence built from the expected code. `done` and `result` are checked at the falling edge after edge N(N+1)+N, and `result` is compared with its old value in every cycle before that. The comparator input comes from a behavioural serial DAC in the bench, so a wrong bit order or a wrong weight shows up as a wrong code.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHARE = 2'd2,
    ST_CMP   = 2'd3
  } sar_state_t;

  // charge strobes needed by one full conversion of n bits
  function automatic int unsigned charge_steps_total(input int unsigned n);
    return n * (n + 1);
  endfunction

  // clock edges from start acceptance to done
  function automatic int unsigned conv_cycles(input int unsigned n);
    return n * (n + 1) + n;
  endfunction

  // index width for counters over n positions
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_serial_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       last_bit,
  input  logic       last_dec,
  output sar_state_t state,
  output logic       conv_start,
  output logic       conv_done,
  output logic       bit_adv,
  output logic       dec_adv
);

  sar_state_t state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_LOAD;
      ST_LOAD:  state_nx = ST_SHARE;
      ST_SHARE: state_nx = last_bit ? ST_CMP : ST_LOAD;
      ST_CMP:   state_nx = last_dec ? ST_IDLE : ST_LOAD;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign conv_start = (state == ST_IDLE) && start;
  assign conv_done  = (state == ST_CMP) && last_dec;
  assign bit_adv    = (state == ST_SHARE) && !last_bit;
  assign dec_adv    = (state == ST_CMP) && !last_dec;

endmodule

// File: rtl/sar_bit_counter.sv
module sar_bit_counter #(
  parameter int RES_BITS = 4,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             bit_adv,
  input  logic             dec_adv,
  output logic [IDX_W-1:0] dec_idx,
  output logic [IDX_W-1:0] bit_pos,
  output logic             last_bit,
  output logic             last_dec
);

  localparam logic [IDX_W-1:0] LAST_DEC_IDX = IDX_W'(RES_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || conv_start) begin
      dec_idx <= '0;
      bit_pos <= '0;
    end else if (bit_adv) begin
      bit_pos <= bit_pos + 1'b1;
    end else if (dec_adv) begin
      bit_pos <= '0;
      dec_idx <= dec_idx + 1'b1;
    end
  end

  // decision (dec_idx+1) streams dec_idx+1 bits: positions 0..dec_idx
  assign last_bit = (bit_pos == dec_idx);
  assign last_dec = (dec_idx == LAST_DEC_IDX);

endmodule

// File: rtl/sar_trial_stream.sv
module sar_trial_stream #(
  parameter int RES_BITS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                streaming,
  input  logic [RES_BITS-1:0] work,
  input  logic [IDX_W-1:0]    dec_idx,
  input  logic [IDX_W-1:0]    bit_pos,
  output logic                dac_bit
);

  // Trial word of decision L = dec_idx+1, sent lowest weight first.
  // Position 0 is the trial 1. Position p >= 1 carries the settled bit
  // stored at work[RES_BITS-1-dec_idx+p]; the last one is work[RES_BITS-1].
  function automatic logic pick_bit(input logic [RES_BITS-1:0] w,
                                    input int unsigned d,
                                    input int unsigned p);
    logic r;
    int unsigned sel;
    r = 1'b1;
    if (p != 0) begin
      sel = RES_BITS - 1 - d + p;
      r = 1'b0;
      for (int j = 0; j < RES_BITS; j++)
        if (sel == j) r = w[j];
    end
    return r;
  endfunction

  assign dac_bit = streaming &&
                   pick_bit(work, int'(unsigned'(dec_idx)), int'(unsigned'(bit_pos)));

endmodule

// File: rtl/sar_decision_reg.sv
module sar_decision_reg #(
  parameter int RES_BITS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_start,
  input  logic                capture,
  input  logic                conv_done,
  input  logic [IDX_W-1:0]    dec_idx,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] work,
  output logic [RES_BITS-1:0] result,
  output logic                done
);

  logic [RES_BITS-1:0] work_nx;

  // one cell per result bit; decision dec_idx owns bit RES_BITS-1-dec_idx
  for (genvar i = 0; i < RES_BITS; i++) begin : g_cell
    logic own;
    assign own = capture && (dec_idx == IDX_W'(RES_BITS - 1 - i));
    assign work_nx[i] = conv_start ? 1'b0 : (own ? cmp_in : work[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) work <= '0;
    else        work <= work_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else if (conv_done) begin
      result <= work_nx;
      done   <= 1'b1;
    end else if (conv_start) begin
      done   <= 1'b0;
    end
  end

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_serial_pkg::*;
#(
  parameter int RES_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cmp_in,
  output logic                dac_bit,
  output logic                chg_load,
  output logic                chg_share,
  output logic                cmp_strobe,
  output logic [RES_BITS-1:0] result,
  output logic                done
);

  localparam int IDX_W = idx_width(RES_BITS);

  sar_state_t          state;
  logic                conv_start;
  logic                conv_done;
  logic                bit_adv;
  logic                dec_adv;
  logic                last_bit;
  logic                last_dec;
  logic [IDX_W-1:0]    dec_idx;
  logic [IDX_W-1:0]    bit_pos;
  logic [RES_BITS-1:0] work;
  logic                streaming;

  sar_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .last_bit   (last_bit),
    .last_dec   (last_dec),
    .state      (state),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .bit_adv    (bit_adv),
    .dec_adv    (dec_adv)
  );

  sar_bit_counter #(.RES_BITS(RES_BITS), .IDX_W(IDX_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .bit_adv    (bit_adv),
    .dec_adv    (dec_adv),
    .dec_idx    (dec_idx),
    .bit_pos    (bit_pos),
    .last_bit   (last_bit),
    .last_dec   (last_dec)
  );

  assign streaming  = (state == ST_LOAD) || (state == ST_SHARE);
  assign chg_load   = (state == ST_LOAD);
  assign chg_share  = (state == ST_SHARE);
  assign cmp_strobe = (state == ST_CMP);

  sar_trial_stream #(.RES_BITS(RES_BITS), .IDX_W(IDX_W)) u_stream (
    .streaming (streaming),
    .work      (work),
    .dec_idx   (dec_idx),
    .bit_pos   (bit_pos),
    .dac_bit   (dac_bit)
  );

  sar_decision_reg #(.RES_BITS(RES_BITS), .IDX_W(IDX_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .capture    (cmp_strobe),
    .conv_done  (conv_done),
    .dec_idx    (dec_idx),
    .cmp_in     (cmp_in),
    .work       (work),
    .result     (result),
    .done       (done)
  );

endmodule

// File: rtl/sar_serial_sva.sv
module sar_serial_sva #(
  parameter int RES_BITS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                dac_bit,
  input logic                chg_load,
  input logic                chg_share,
  input logic                cmp_strobe,
  input logic [RES_BITS-1:0] result,
  input logic                done,
  input logic                conv_start,
  input logic                conv_done
);

  logic [15:0] loads_in_dec;
  logic [15:0] dec_num;
  logic [15:0] steps;
  logic        busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loads_in_dec <= '0;
      dec_num      <= '0;
      steps        <= '0;
      busy         <= 1'b0;
    end else begin
      if (conv_start) begin
        loads_in_dec <= '0;
        dec_num      <= '0;
        steps        <= '0;
        busy         <= 1'b1;
      end else begin
        if (cmp_strobe) begin
          loads_in_dec <= '0;
          dec_num      <= dec_num + 16'd1;
        end else if (chg_load) begin
          loads_in_dec <= loads_in_dec + 16'd1;
        end
        if (chg_load || chg_share) steps <= steps + 16'd1;
        if (conv_done) busy <= 1'b0;
      end
    end
  end

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chg_load, chg_share, cmp_strobe}));

  assert_load_then_share_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chg_load |=> chg_share);

  assert_dec_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> (loads_in_dec == dec_num + 16'd1));

  assert_bit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chg_share |-> ($past(chg_load) && (dac_bit == $past(dac_bit))));

  assert_cmp_after_share_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> $past(chg_share));

  assert_total_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (steps == 16'(RES_BITS * (RES_BITS + 1))));

  assert_done_with_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmp_strobe));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !conv_start);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(result));

  // R1: reset state, checked once reset is released
  always_ff @(posedge clk) begin
    if (rst_n && !busy && !done && !start)
      assert_idle_quiet_R1: assert (!chg_load && !chg_share && !cmp_strobe && !dac_bit);
  end

endmodule

bind sar_serial_seq sar_serial_sva #(.RES_BITS(RES_BITS)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .dac_bit    (dac_bit),
  .chg_load   (chg_load),
  .chg_share  (chg_share),
  .cmp_strobe (cmp_strobe),
  .result     (result),
  .done       (done),
  .conv_start (conv_start),
  .conv_done  (conv_done)
);

// File: tb/tb_sar_serial_seq.sv
`timescale 1ns/1ps
module tb_sar_serial_seq;

  localparam int N    = 4;
  localparam int FULL = 1 << N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp_in;
  logic         dac_bit;
  logic         chg_load;
  logic         chg_share;
  logic         cmp_strobe;
  logic [N-1:0] result;
  logic         done;

  int checks = 0;
  int fails  = 0;
  int vin    = 0;   // input level in units of full scale / 2^N

  always #2 clk = ~clk;

  sar_serial_seq #(.RES_BITS(N)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmp_in     (cmp_in),
    .dac_bit    (dac_bit),
    .chg_load   (chg_load),
    .chg_share  (chg_share),
    .cmp_strobe (cmp_strobe),
    .result     (result),
    .done       (done)
  );

  // behavioural serial DAC: voltage kept in units of full scale / 2^N
  int  dac_v;
  logic c1_bit;
  always @(posedge clk) begin
    if (!rst_n) begin
      dac_v  <= 0;
      c1_bit <= 1'b0;
    end else if (cmp_strobe) begin
      dac_v  <= 0;
    end else if (chg_load) begin
      c1_bit <= dac_bit;
    end else if (chg_share) begin
      dac_v  <= (dac_v + (c1_bit ? FULL : 0)) / 2;
    end
  end
  assign cmp_in = (vin >= dac_v);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({chg_load, chg_share, cmp_strobe, dac_bit} == 4'b0, "R1 strobes in reset",
        {chg_load, chg_share, cmp_strobe, dac_bit}, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(result == '0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({chg_load, chg_share, cmp_strobe, dac_bit, done} == 5'b0, "R1 idle after reset",
        {chg_load, chg_share, cmp_strobe, dac_bit, done}, 0);
  endtask

  // one conversion of input v; poke raises start mid-conversion (R8)
  task automatic t_convert(input int v, input bit poke, input string tag);
    logic [N-1:0] expv = N'(v);
    logic [N-1:0] prev;
    int seq_bad = 0, strb_bad = 0, hold_bad = 0, steps = 0, cyc = 0;
    vin = v;
    prev = result;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;   // now in cycle 1 after the accepting edge
    chk(done == 1'b0, {"R7 done cleared ", tag}, done, 0);
    for (int k = 1; k <= N; k++) begin
      for (int p = 0; p < k; p++) begin
        // expected bit: trial 1, then settled bits b_(k-p) by rising weight
        logic e = (p == 0) ? 1'b1 : expv[N - (k - p)];
        if (cyc != 0) @(negedge clk);
        cyc++;
        start = (poke && k == 2 && p == 0);
        if (!(chg_load && !chg_share && !cmp_strobe)) strb_bad++;
        if (dac_bit !== e) seq_bad++;
        if (result !== prev) hold_bad++;
        steps += chg_load + chg_share;
        @(negedge clk);
        cyc++;
        start = 1'b0;
        if (!(!chg_load && chg_share && !cmp_strobe)) strb_bad++;
        if (dac_bit !== e) seq_bad++;
        if (result !== prev) hold_bad++;
        steps += chg_load + chg_share;
      end
      @(negedge clk);
      cyc++;
      if (!(!chg_load && !chg_share && cmp_strobe)) strb_bad++;
      if (result !== prev) hold_bad++;
      if (done !== 1'b0) hold_bad++;
    end
    chk(seq_bad == 0, {"R3 trial word order ", tag}, seq_bad, 0);
    chk(strb_bad == 0, {"R2/R4 strobe pattern ", tag}, strb_bad, 0);
    chk(steps == N * (N + 1), {"R6 charge steps ", tag}, steps, N * (N + 1));
    chk(hold_bad == 0, {"R10 result held while converting ", tag}, hold_bad, 0);
    @(negedge clk);
    chk(cyc == N * (N + 1) + N && done == 1'b1, {"R6 R7 done on time ", tag}, done, 1);
    chk(result == expv, {"R5 result ", tag}, result, expv);
  endtask

  task automatic t_hold();
    logic [N-1:0] r0 = result;
    int bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!done || result !== r0 || chg_load || chg_share || cmp_strobe) bad++;
    end
    chk(bad == 0, "R7 done and result held while idle", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_convert(13, 1'b0, "R9 13/16");
    chk(result == 4'b1101, "R9 13/16 gives 1101", result, 13);
    t_hold();
    t_convert(0, 1'b0, "zero");
    t_convert(15, 1'b0, "full");
    t_convert(6, 1'b1, "R8 start during run");
    t_convert(9, 1'b0, "mid");
    t_convert(8, 1'b1, "R8 half scale");
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule